// File: doc/BRIEF.md
# Display Output Shutdown Sequencer

This block decodes a write-only command word in a display timing controller and turns the controller's four output sub-units off. The four sub-units are the pixel clock, the sync timing, the panel-on line and the backlight PWM. The block offers two ways to turn a sub-unit off. A deferred disable waits for the frame in progress to finish, so that no pulse is cut short. An immediate reset acts at once, even if that breaks a pulse width. A write is accepted only when it targets the command offset and the write-protect flag is clear.

Each sub-unit has its own small state machine with three named states:

- `U_OFF`: the sub-unit is idle and its enable is low.
- `U_ON`: the sub-unit is running.
- `U_PEND`: the sub-unit is running, but a disable is waiting for the end of the frame.

The transitions are:

- `U_OFF -> U_ON` on an enable pulse.
- `U_ON -> U_PEND` on a deferred disable.
- `U_PEND -> U_OFF` on the end-of-frame strobe.
- `any -> U_OFF` on an immediate reset. A reset outranks every other event and discards any pending disable.

The same command word can also raise the shutdown line and the colour-mode line. When the colour-mode line rises from low, the block also emits a one-cycle request for a "colour mode off" command. The timing generator and the PWM lie outside this block. They consume the enables and reset pulses, and the timing generator returns the end-of-frame strobe.

Top module: `disp_off_seq`

## Requirements
- R1: Only a write to byte address 0x24 acts; a write to any other address changes no output.
- R2: While `wprot` is high a write changes no output.
- R3: A data bit written as 0 has no effect; only 1 bits act.
- R4: Data bits 0..3 (pixel clock, sync, panel-on, PWM) on an enabled sub-unit leave its enable high until the end-of-frame strobe, however many cycles pass.
- R5: On the cycle after `frame_end` is sampled high, every pending sub-unit's enable is low. The pending state is then cleared, so a later strobe with no new write turns nothing off.
- R6: Data bits 8..11 cause a one-cycle high on the matching `unit_rst` bit. In that same cycle the sub-unit's enable is low, and the enable stays low until the sub-unit is enabled again.
- R7: If a disable and a reset for the same sub-unit arrive in one write, the reset wins and the pending disable is discarded.
- R8: A pulse on `unit_on[i]` raises `unit_en[i]` from low on the next cycle.
- R9: Data bit 5 drives `shutdown` high on the cycle after the write. It stays high until block reset.
- R10: Data bit 6 drives `cmode` high. `cmode_off_req` pulses for exactly one cycle only when `cmode` was low before.
- R11: After reset all enables, reset pulses, `shutdown`, `cmode` and `cmode_off_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| wprot | input | 1 | Write-protect flag; when high, writes are ignored |
| frame_end | input | 1 | One-cycle end-of-frame strobe from the timing engine |
| unit_on | input | 4 | Per-sub-unit enable pulses |
| unit_en | output | 4 | Enables: [0] pixel clock, [1] sync, [2] panel-on, [3] PWM |
| unit_rst | output | 4 | One-cycle immediate reset pulses, same bit order |
| shutdown | output | 1 | Display shutdown line |
| cmode | output | 1 | Colour-mode line |
| cmode_off_req | output | 1 | One-cycle request to send a colour-mode-off command |

## Verification
Every result comes from a register one edge after the input is sampled. The results are the reset pulses, the enables after a write or an enable pulse, `shutdown`, `cmode` and `cmode_off_req`. The fall of an enable after `frame_end` also arrives one edge after the strobe is sampled. The bench drives each input on a falling edge and samples on the next falling edge, which is exactly the first cycle in which the result is due. For the deferred cases it also samples before the strobe, to show that nothing acts early. Pulse widths are checked by sampling one cycle later again and expecting the pulse to be low.

// File: rtl/disp_off_pkg.sv
package disp_off_pkg;
    localparam int NUM_UNITS = 4;
    localparam int DIS_LSB   = 0;
    localparam int RST_LSB   = 8;
    localparam int SHDN_BIT  = 5;
    localparam int CMODE_BIT = 6;

    typedef enum logic [1:0] {
        U_OFF  = 2'd0,
        U_ON   = 2'd1,
        U_PEND = 2'd2
    } unit_state_e;
endpackage

// File: rtl/disp_off_decode.sv
module disp_off_decode #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int N_UNIT = disp_off_pkg::NUM_UNITS,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h24
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wprot,
    output logic [N_UNIT-1:0] dis_req,
    output logic [N_UNIT-1:0] rst_req,
    output logic              shdn_req,
    output logic              cmode_req
);
    import disp_off_pkg::*;

    logic hit;

    always_comb begin
        hit       = wr_en && (wr_addr == REG_OFS) && !wprot;
        dis_req   = hit ? wr_data[DIS_LSB +: N_UNIT] : '0;
        rst_req   = hit ? wr_data[RST_LSB +: N_UNIT] : '0;
        shdn_req  = hit && wr_data[SHDN_BIT];
        cmode_req = hit && wr_data[CMODE_BIT];
    end
endmodule

// File: rtl/disp_unit_fsm.sv
module disp_unit_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic on_req,
    input  logic dis_req,
    input  logic rst_req,
    input  logic frame_end,
    output logic en,
    output logic rst_pulse
);
    import disp_off_pkg::*;

    unit_state_e state_q, state_d;
    logic        rst_q;

    always_comb begin
        state_d = state_q;
        if (rst_req) begin
            state_d = U_OFF;
        end else begin
            unique case (state_q)
                U_OFF:   if (on_req)    state_d = U_ON;
                U_ON:    if (dis_req)   state_d = U_PEND;
                U_PEND:  if (frame_end) state_d = U_OFF;
                default:                state_d = U_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= U_OFF;
            rst_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rst_q   <= rst_req;
        end
    end

    always_comb begin
        en        = (state_q != U_OFF);
        rst_pulse = rst_q;
    end

    // R4: a pending disable does not act without a strobe or reset
    p_no_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == U_PEND && !frame_end && !rst_req) |=> en);
    // R5: the enable only falls after a strobe or reset request
    p_fall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> $past(frame_end || rst_req));
    // R6: a reset pulse coincides with the sub-unit being off
    p_rst_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> !en);
endmodule

// File: rtl/disp_line_ctl.sv
module disp_line_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic shdn_req,
    input  logic cmode_req,
    output logic shutdown,
    output logic cmode,
    output logic cmode_off_req
);
    logic shdn_q, cmode_q, cmoff_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shdn_q  <= 1'b0;
            cmode_q <= 1'b0;
            cmoff_q <= 1'b0;
        end else begin
            shdn_q  <= shdn_q | shdn_req;
            cmode_q <= cmode_q | cmode_req;
            cmoff_q <= cmode_req && !cmode_q;
        end
    end

    always_comb begin
        shutdown      = shdn_q;
        cmode         = cmode_q;
        cmode_off_req = cmoff_q;
    end

    // R10: the command request only marks a rising colour-mode line
    p_cmoff_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmoff_q |-> (cmode_q && !$past(cmode_q)));
    // R9: shutdown never drops while out of reset
    p_shdn_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(shdn_q));
endmodule

// File: rtl/disp_off_seq.sv
module disp_off_seq #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int N_UNIT = disp_off_pkg::NUM_UNITS,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wprot,
    input  logic              frame_end,
    input  logic [N_UNIT-1:0] unit_on,
    output logic [N_UNIT-1:0] unit_en,
    output logic [N_UNIT-1:0] unit_rst,
    output logic              shutdown,
    output logic              cmode,
    output logic              cmode_off_req
);
    logic [N_UNIT-1:0] dis_req, rst_req;
    logic              shdn_req, cmode_req;

    disp_off_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_UNIT(N_UNIT), .REG_OFS(REG_OFS)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wprot(wprot),
        .dis_req(dis_req), .rst_req(rst_req),
        .shdn_req(shdn_req), .cmode_req(cmode_req)
    );

    for (genvar g = 0; g < N_UNIT; g++) begin : g_unit
        disp_unit_fsm u_fsm (
            .clk(clk), .rst_n(rst_n),
            .on_req(unit_on[g]), .dis_req(dis_req[g]), .rst_req(rst_req[g]),
            .frame_end(frame_end),
            .en(unit_en[g]), .rst_pulse(unit_rst[g])
        );
    end

    disp_line_ctl u_lines (
        .clk(clk), .rst_n(rst_n),
        .shdn_req(shdn_req), .cmode_req(cmode_req),
        .shutdown(shutdown), .cmode(cmode), .cmode_off_req(cmode_off_req)
    );

    // R2: a protected write fires no reset pulse
    p_wprot_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wprot) |=> (unit_rst == '0));
    // R1: a write to another address fires no reset pulse
    p_addr_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != REG_OFS) |=> (unit_rst == '0));
    // R7: a reset on a unit leaves it off on the next cycle
    p_rst_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req != '0) |=> ((unit_en & $past(rst_req)) == '0));
endmodule

// File: tb/test_disp_off_seq.sv
module test_disp_off_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wprot = 1'b0;
    logic        frame_end = 1'b0;
    logic [3:0]  unit_on = '0;
    logic [3:0]  unit_en, unit_rst;
    logic        shutdown, cmode, cmode_off_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    disp_off_seq i_disp_off_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wprot(wprot), .frame_end(frame_end),
        .unit_on(unit_on), .unit_en(unit_en), .unit_rst(unit_rst),
        .shutdown(shutdown), .cmode(cmode), .cmode_off_req(cmode_off_req)
    );

    typedef struct packed {
        logic        wp;
        logic [7:0]  addr;
        logic [15:0] data;
        logic [3:0]  on;
        logic        fe;
        logic [3:0]  rst;
        logic [3:0]  pre;
        logic [3:0]  post;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h24, 16'h0000, 4'hF, 1'b1, 4'h0, 4'hF, 4'hF}, // R8 R3
        '{1'b1, 8'h24, 16'h0F0F, 4'h0, 1'b1, 4'h0, 4'hF, 4'hF}, // R2
        '{1'b0, 8'h20, 16'h0F0F, 4'h0, 1'b1, 4'h0, 4'hF, 4'hF}, // R1
        '{1'b0, 8'h24, 16'h0005, 4'h0, 1'b1, 4'h0, 4'hF, 4'hA}, // R4 R5
        '{1'b0, 8'h24, 16'h0000, 4'h5, 1'b1, 4'h0, 4'hF, 4'hF}, // R5 cleared
        '{1'b0, 8'h24, 16'h0200, 4'h0, 1'b1, 4'h2, 4'hD, 4'hD}, // R6
        '{1'b0, 8'h24, 16'h0808, 4'h2, 1'b1, 4'h8, 4'h7, 4'h7}, // R7
        '{1'b0, 8'h24, 16'h0000, 4'h8, 1'b1, 4'h0, 4'hF, 4'hF}, // R7 pending gone
        '{1'b0, 8'h24, 16'h000F, 4'h0, 1'b0, 4'h0, 4'hF, 4'hF}, // R4 held
        '{1'b0, 8'h24, 16'h0000, 4'h0, 1'b1, 4'h0, 4'hF, 4'h0}  // R5 commit
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic wp, input logic [7:0] a, input logic [31:0] d);
        wprot = wp; wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wprot = 1'b0; wr_data = '0; wr_addr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 unit_en", unit_en, 0);
        check("R11 unit_rst", unit_rst, 0);
        check("R11 lines", {shutdown, cmode, cmode_off_req}, 0);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].on != 4'h0) begin
                unit_on = VECS[v].on;
                @(negedge clk);
                unit_on = '0;
            end
            wr(VECS[v].wp, VECS[v].addr, {16'h0, VECS[v].data});
            check($sformatf("vec %0d rst", v), unit_rst, VECS[v].rst);
            check($sformatf("vec %0d en before strobe", v), unit_en, VECS[v].pre);
            frame_end = VECS[v].fe;
            @(negedge clk);
            frame_end = 1'b0;
            check($sformatf("vec %0d en after strobe", v), unit_en, VECS[v].post);
        end

        // R6 pulse width is one cycle
        unit_on = 4'hF; @(negedge clk); unit_on = '0;
        wr(1'b0, 8'h24, 32'h0100);
        check("R6 pulse high", unit_rst, 4'h1);
        check("R6 unit off", unit_en, 4'hE);
        @(negedge clk);
        check("R6 pulse one cycle", unit_rst, 4'h0);
        check("R6 stays off", unit_en, 4'hE);

        // R2 shutdown blocked by protect, R9 shutdown set
        wr(1'b1, 8'h24, 32'h0020);
        check("R2 shutdown protected", shutdown, 0);
        wr(1'b0, 8'h24, 32'h0020);
        check("R9 shutdown set", shutdown, 1);
        check("R9 cmode untouched", cmode, 0);
        wr(1'b0, 8'h24, 32'h0000);
        check("R9 shutdown sticky", shutdown, 1);

        // R10 colour mode and off request
        wr(1'b0, 8'h24, 32'h0040);
        check("R10 cmode set", cmode, 1);
        check("R10 off request", cmode_off_req, 1);
        @(negedge clk);
        check("R10 request one cycle", cmode_off_req, 0);
        wr(1'b0, 8'h24, 32'h0040);
        check("R10 no request when high", cmode_off_req, 0);
        check("R10 cmode held", cmode, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule